// File: doc/BRIEF.md
# Accumulator Operand Fetch Unit

This block fetches the operand of a load into a single accumulator. A request carries a three-bit mode code and an address-sized field and is started by a one-cycle strobe. The block works out the effective address from the field, from an auxiliary register R1, or from a word read out of its own memory. It then performs the memory reads that the mode needs, one after another, and writes the result into the accumulator.

When the operation is complete, the block reports the effective address and a flag that says whether an effective address applies to the mode. A single-cycle done pulse marks completion. The surrounding logic, which in this project is the testbench, loads R1 and the word-addressed memory through simple write ports while the block is idle.

Control is a four-state machine:

- **IDLE** waits for a start. From IDLE, the transition *start-fast* goes to DONE for the immediate and register modes. The transition *start-read* goes to READ1 for the four modes that read memory.
- **READ1** takes the first memory word. The transition *first-final* goes to DONE. For memory-indirect mode, the transition *pointer-fetched* goes to READ2 instead.
- **READ2** takes the word at the pointer. The transition *second-final* goes to DONE.
- **DONE** raises the done pulse. The transition *release* returns to IDLE.

Memory reads have a one-cycle latency.

Top module: `ea_operand_unit`

## Requirements
- R1: Mode code 0 (immediate) loads the field, zero-extended, into the accumulator. It leaves the effective address at 0 with its flag low, and done rises one cycle after the accepted start.
- R2: Mode code 1 (register) loads R1 into the accumulator. It leaves the effective address at 0 with its flag low, and done rises one cycle after start.
- R3: Mode code 2 (direct) uses the field as the effective address, with the flag high, and loads the memory word at that address. Done rises two cycles after start.
- R4: Mode code 3 (register indirect) uses the low ADDR_W bits of R1 as the effective address and loads the memory word there. Done rises two cycles after start.
- R5: Mode code 4 (memory indirect) uses the low ADDR_W bits of the word stored at the field as the effective address. It loads the word at that address, performing two dependent reads, and done rises three cycles after start.
- R6: Mode code 5 (indexed) uses the field plus the low ADDR_W bits of R1, modulo 2^ADDR_W, as the effective address and loads the word there. Done rises two cycles after start.
- R7: Done is high for exactly one cycle per operation, and busy is high from the cycle after an accepted start through the done cycle.
- R8: A start that arrives while busy is high is ignored and does not alter the operation in progress.
- R9: Mode codes 6 and 7 are reserved. A start with either code leaves the block idle, gives no done pulse and leaves the accumulator unchanged.
- R10: After reset, the accumulator, the effective address, the flag, done and busy are all 0.
- R11: While the block is idle and start is low, the accumulator and the effective address hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand fetch; sampled only while idle |
| mode | input | 3 | Addressing mode code (0..5 legal) |
| field | input | ADDR_W | Address or immediate field |
| r1_we | input | 1 | Write enable for R1 |
| r1_wdata | input | DATA_W | New value of R1 |
| mem_we | input | 1 | Memory write enable |
| mem_waddr | input | ADDR_W | Memory write address |
| mem_wdata | input | DATA_W | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc | output | DATA_W | Accumulator |
| ea | output | ADDR_W | Effective address of the last operation |
| ea_valid | output | 1 | An effective address applies to the last operation |

## Verification
The properties assume that mode and field are held steady during the cycle in which start is sampled. They also assume that R1 and memory are written only while the block is idle, so that a fetch never races a write to a location it reads. The stimulus follows these rules: the bench loads memory and R1 before each batch and drives requests only at falling clock edges while busy is low. The one exception is the deliberate start issued during a running fetch to exercise the ignore rule.

// File: rtl/eou_pkg.sv
package eou_pkg;

    typedef enum logic [2:0] {
        M_IMM  = 3'd0,
        M_REG  = 3'd1,
        M_DIR  = 3'd2,
        M_RIND = 3'd3,
        M_MIND = 3'd4,
        M_IDX  = 3'd5
    } mode_t;

    localparam logic [2:0] MODE_LAST = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ1 = 2'd1,
        S_READ2 = 2'd2,
        S_DONE  = 2'd3
    } state_t;

endpackage

// File: rtl/eou_mem.sv
module eou_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // write port used by the loader, read port registered (one-cycle latency)
    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
        rdata <= words[raddr];
    end
endmodule

// File: rtl/eou_addr_gen.sv
module eou_addr_gen
    import eou_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] r1_lo,
    output logic [ADDR_W-1:0] first_addr
);
    mode_t mode_e;
    assign mode_e = mode_t'(mode);

    // address of the first memory read; also the final EA except in memory-indirect
    always_comb begin
        unique case (mode_e)
            M_RIND:  first_addr = r1_lo;
            M_IDX:   first_addr = field + r1_lo;
            default: first_addr = field;
        endcase
    end
endmodule

// File: rtl/eou_ctrl.sv
module eou_ctrl
    import eou_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [DATA_W-1:0] r1,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic              done,
    output logic              busy
);
    localparam int PAD_W = DATA_W - ADDR_W;

    state_t state_q, state_d;
    mode_t  mode_e;
    logic   mode_ok;
    logic   accept;
    logic   fast;
    logic   ind_q;

    assign mode_e  = mode_t'(mode);
    assign mode_ok = (mode <= MODE_LAST);
    assign accept  = start && mode_ok && (state_q == S_IDLE);
    assign fast    = (mode_e == M_IMM) || (mode_e == M_REG);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = fast ? S_DONE : S_READ1;
                end
            end
            S_READ1: state_d = ind_q ? S_READ2 : S_DONE;
            S_READ2: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            ea       <= '0;
            ea_valid <= 1'b0;
            ind_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        ind_q <= (mode_e == M_MIND);
                        unique case (mode_e)
                            M_IMM: begin
                                acc      <= {{PAD_W{1'b0}}, field};
                                ea       <= '0;
                                ea_valid <= 1'b0;
                            end
                            M_REG: begin
                                acc      <= r1;
                                ea       <= '0;
                                ea_valid <= 1'b0;
                            end
                            default: begin
                                ea       <= first_addr;
                                ea_valid <= 1'b1;
                            end
                        endcase
                    end
                end
                S_READ1: begin
                    if (ind_q) begin
                        ea <= rd_data[ADDR_W-1:0];
                    end else begin
                        acc <= rd_data;
                    end
                end
                S_READ2: acc <= rd_data;
                S_DONE:  ;
                default: ;
            endcase
        end
    end

    // memory read address: first read issued from IDLE, pointer read from READ1
    always_comb begin
        unique case (state_q)
            S_IDLE:  rd_addr = first_addr;
            S_READ1: rd_addr = rd_data[ADDR_W-1:0];
            default: rd_addr = ea;
        endcase
    end

    assign done = (state_q == S_DONE);
    assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] field,
    input  logic              r1_we,
    input  logic [DATA_W-1:0] r1_wdata,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid
);
    logic [DATA_W-1:0] r1_q;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_q <= '0;
        end else if (r1_we) begin
            r1_q <= r1_wdata;
        end
    end

    eou_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
        .mode       (mode),
        .field      (field),
        .r1_lo      (r1_q[ADDR_W-1:0]),
        .first_addr (first_addr)
    );

    eou_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    eou_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .field      (field),
        .r1         (r1_q),
        .first_addr (first_addr),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .acc        (acc),
        .ea         (ea),
        .ea_valid   (ea_valid),
        .done       (done),
        .busy       (busy)
    );
endmodule

// File: rtl/eou_checker.sv
module eou_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        mode,
    input logic [ADDR_W-1:0] field,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] acc,
    input logic [ADDR_W-1:0] ea,
    input logic              ea_valid
);
    localparam int PAD_W = DATA_W - ADDR_W;

    a_r1_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 3'd0) |=>
            (done && !ea_valid && acc == {{PAD_W{1'b0}}, $past(field)}));

    a_r3_direct_ea: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 3'd2) |=> (!done) ##1
            (done && ea_valid && ea == $past(field, 2)));

    a_r5_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 3'd4) |=> (!done) ##1 (!done) ##1
            (done && ea_valid));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode > 3'd5) |=> (!busy && $stable(acc)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(acc) && $stable(ea)));
endmodule

bind ea_operand_unit eou_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .field    (field),
    .busy     (busy),
    .done     (done),
    .acc      (acc),
    .ea       (ea),
    .ea_valid (ea_valid)
);

// File: tb/ea_operand_unit_tb_top.sv
`timescale 1ns/1ps
module ea_operand_unit_tb_top;
    localparam int DW = 16;
    localparam int AW = 10;
    localparam int NV = 10;

    // {mode[3], field[10], exp_acc[16], exp_ea[10], exp_valid[1]}
    localparam logic [39:0] VEC [NV] = '{
        {3'd0, 10'd200,  16'd200,  10'd0,   1'b0},  // R1
        {3'd1, 10'd200,  16'd100,  10'd0,   1'b0},  // R2
        {3'd2, 10'd200,  16'd400,  10'd200, 1'b1},  // R3
        {3'd3, 10'd200,  16'd250,  10'd100, 1'b1},  // R4
        {3'd4, 10'd200,  16'd750,  10'd400, 1'b1},  // R5
        {3'd5, 10'd200,  16'd650,  10'd300, 1'b1},  // R6
        {3'd2, 10'd300,  16'd650,  10'd300, 1'b1},  // R3
        {3'd4, 10'd100,  16'h1234, 10'd250, 1'b1},  // R5
        {3'd0, 10'd1023, 16'd1023, 10'd0,   1'b0},  // R1
        {3'd5, 10'd0,    16'd250,  10'd100, 1'b1}   // R6
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [AW-1:0] field = '0;
    logic          r1_we = 1'b0;
    logic [DW-1:0] r1_wdata = '0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic          busy, done, ea_valid;
    logic [DW-1:0] acc;
    logic [AW-1:0] ea;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ea_operand_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
        .r1_we(r1_we), .r1_wdata(r1_wdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .acc(acc), .ea(ea), .ea_valid(ea_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put_mem(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic put_r1(input logic [DW-1:0] d);
        @(negedge clk);
        r1_we = 1'b1; r1_wdata = d;
        @(negedge clk);
        r1_we = 1'b0;
    endtask

    function automatic int lat_of(input logic [2:0] m);
        if (m <= 3'd1) return 1;
        if (m == 3'd4) return 3;
        return 2;
    endfunction

    // issue one request and wait for done; returns cycles to done
    task automatic run_op(input logic [2:0] m, input logic [AW-1:0] f, output int lat);
        @(negedge clk);
        start = 1'b1; mode = m; field = f;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R10: reset values
        check("R10 acc", acc, 0);
        check("R10 ea", ea, 0);
        check("R10 ea_valid", ea_valid, 0);
        check("R10 done", done, 0);
        check("R10 busy", busy, 0);
        rst_n = 1'b1;

        put_r1(16'd100);
        put_mem(10'd100, 16'd250);
        put_mem(10'd200, 16'd400);
        put_mem(10'd300, 16'd650);
        put_mem(10'd400, 16'd750);
        put_mem(10'd250, 16'h1234);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] vm;
            vm = VEC[i][39:37];
            run_op(vm, VEC[i][36:27], lat);
            check($sformatf("R%0d latency v%0d", vm + 1, i), lat, lat_of(vm));
            check($sformatf("R%0d acc v%0d", vm + 1, i), acc, VEC[i][26:11]);
            check($sformatf("R%0d ea v%0d", vm + 1, i), ea, VEC[i][10:1]);
            check($sformatf("R%0d ea_valid v%0d", vm + 1, i), ea_valid, VEC[i][0]);
            @(negedge clk);
            check("R7 done falls", done, 0);
            check("R7 busy falls", busy, 0);
        end

        // R11: idle hold
        repeat (3) @(negedge clk);
        check("R11 acc hold", acc, 16'd250);
        check("R11 ea hold", ea, 10'd100);

        // R6: index wraps modulo 2^ADDR_W
        put_r1(16'h03F0);
        put_mem(10'h010, 16'hBEEF);
        run_op(3'd5, 10'h020, lat);
        check("R6 wrap acc", acc, 16'hBEEF);
        check("R6 wrap ea", ea, 10'h010);
        run_op(3'd1, 10'h000, lat);
        check("R2 reg acc", acc, 16'h03F0);
        // R4: only low R1 bits form the address
        put_r1(16'hFC64);
        run_op(3'd3, 10'h000, lat);
        check("R4 low bits ea", ea, 10'h064);
        check("R4 low bits acc", acc, 16'd250);

        // R5: pointer upper bits dropped
        put_mem(10'd5, 16'hFC07);
        put_mem(10'd7, 16'h5A5A);
        run_op(3'd4, 10'd5, lat);
        check("R5 ptr ea", ea, 10'd7);
        check("R5 ptr acc", acc, 16'h5A5A);
        check("R5 ptr latency", lat, 3);

        // R8: start while busy ignored
        @(negedge clk);
        start = 1'b1; mode = 3'd2; field = 10'd300;
        @(negedge clk);
        check("R8 busy", busy, 1);
        mode = 3'd0; field = 10'd3;
        @(negedge clk);
        check("R8 done", done, 1);
        start = 1'b0;
        check("R8 acc", acc, 16'd650);
        check("R8 ea", ea, 10'd300);
        @(negedge clk);
        check("R8 idle after", busy, 0);
        check("R8 acc kept", acc, 16'd650);

        // R9: reserved modes
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            start = 1'b1; mode = 3'(k); field = 10'd9;
            @(negedge clk);
            start = 1'b0;
            check("R9 not busy", busy, 0);
            repeat (3) begin
                check("R9 no done", done, 0);
                @(negedge clk);
            end
            check("R9 acc unchanged", acc, 16'd650);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule